// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Slave

This block is a two-wire SMBus slave that serves a small array of 8-bit configuration registers. A system controller reaches the registers with four transaction kinds: indexed byte write, indexed byte read, block write and block read. The first byte after the write address is a command. Its top bit picks indexed single-byte access (low seven bits give the register offset) or block access, which always begins at register 0 and walks upward.

The bus pins are modelled as open-drain: the block samples SCL and SDA and owns only a pull-low enable for SDA. Both lines are oversampled by the system clock through a synchronizer. Start, repeated start and stop are detected from the sampled lines. Each register bit is one of three kinds, set by parameter masks: writable, read-only, or write-one-to-clear. Chip logic updates any bit through a local write port and sees every register on a flat output bus.

Top module: `smb_idx_regs`

## Requirements
- R1: After reset SDA is released (`sda_oe` = 0) and every register holds its reset value; the default reset bytes for registers 0..7 are 00, FF, 7F, 00, 48, 00, 00, A5.
- R2: The slave acknowledges only the address byte {7'h69, r/w} (0xD2 for write). Any other address gets no acknowledge, and the block ignores the bus until the next start: no register changes.
- R3: A command byte with bit 7 = 1 selects indexed byte mode at offset bits 6:0. The single data byte that follows is acknowledged and stored at that offset. A second data byte in the same transaction is not acknowledged and not stored.
- R4: In byte mode, a repeated start followed by the read address returns the register at the offset, most significant bit first.
- R5: A command byte with bit 7 = 0 selects block mode. The next byte is a byte count, acknowledged and otherwise unused. Data bytes then go to registers 0, 1, 2 and up. A stop after any whole byte leaves the higher registers untouched. A data byte past the last register is not acknowledged.
- R6: In block mode, a read returns first a count equal to the number of registers (8 by default), then register 0 upward, until the master answers a byte with no acknowledge.
- R7: A write leaves read-only bits unchanged. The default writable masks for registers 0..7 are FF, FF, 7F, F0, 00, F0, FF, FF.
- R8: A write-one-to-clear bit is cleared only where a 1 is written, and writing 0 keeps it. By default, bits 3:0 of register 5 are write-one-to-clear.
- R9: A local port write replaces all eight bits of the addressed register, read-only and write-one-to-clear bits included. The new value is visible on `cfg_q` and in bus reads.
- R10: A byte-mode offset at or above the register count is acknowledged. A write there changes nothing, and a read there returns 0x00.
- R11: A repeated start at any point restarts address reception. An unfinished command or data byte is then discarded.
- R12: The slave starts pulling SDA low only while SCL is low, and has SDA released after every stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SMBus clock line |
| sda_i | input | 1 | Sampled SMBus data line |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| hw_we | input | 1 | Local register write strobe |
| hw_idx | input | 8 | Local register index |
| hw_wdata | input | 8 | Local write data (all bits) |
| cfg_q | output | NUM_REGS*8 | All registers, register i at bits 8i+7:8i |

## Verification
Every register is written through the byte path with all-ones, all-zeros and an index-derived pattern. The bench predicts each result by applying that register's writable and clear masks arithmetically, so a wrong mask on any single bit is caught. Block writes that stop early and that run past the last register show whether the pointer walk and its bound are right. Block reads check the returned count and the ordering. Mismatched addresses, out-of-range offsets, a second byte-mode data byte and a repeated start that aborts a command each separate a byte that should be ignored from one that should land.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } st_t;

  typedef enum logic [1:0] {
    RK_ADDR,
    RK_CMD,
    RK_DATA
  } rk_t;

  // Combine a bus write with the old value under the per-bit policy masks.
  function automatic logic [7:0] merge_wr(input logic [7:0] old_v,
                                          input logic [7:0] din,
                                          input logic [7:0] wmask,
                                          input logic [7:0] cmask);
    return (old_v & ~wmask & ~cmask) | (din & wmask & ~cmask) | (old_v & cmask & ~din);
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES:0] scl_sh;
  logic [STAGES:0] sda_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_sh[STAGES-1];
  assign scl_prev = scl_sh[STAGES];
  assign sda_now  = sda_sh[STAGES-1];
  assign sda_prev = sda_sh[STAGES];

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/smb_idx_fsm.sv
module smb_idx_fsm
  import smb_idx_pkg::*;
#(
  parameter int         NUM_REGS   = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       bus_we,
  output logic [7:0] bus_idx,
  output logic [7:0] bus_wdata,
  output logic       sda_oe
);

  localparam logic [7:0] CNT8 = 8'(NUM_REGS);

  st_t        st;
  rk_t        rk;
  logic [7:0] sh;
  logic [3:0] bcnt;
  logic       rd_mode;
  logic       byte_mode;
  logic [6:0] offs;
  logic [7:0] ptr;
  logic       send_cnt;
  logic       cnt_seen;
  logic       one_done;

  logic [7:0] tx_byte;
  logic       ptr_in_rng;

  assign rd_idx     = ptr;
  assign tx_byte    = send_cnt ? CNT8 : rd_data;
  assign ptr_in_rng = (int'(ptr) < NUM_REGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rk        <= RK_ADDR;
      sh        <= '0;
      bcnt      <= '0;
      rd_mode   <= 1'b0;
      byte_mode <= 1'b0;
      offs      <= '0;
      ptr       <= '0;
      send_cnt  <= 1'b0;
      cnt_seen  <= 1'b0;
      one_done  <= 1'b0;
      sda_oe    <= 1'b0;
      bus_we    <= 1'b0;
      bus_idx   <= '0;
      bus_wdata <= '0;
    end else begin
      bus_we <= 1'b0;
      if (start_det) begin
        st     <= ST_RX;
        rk     <= RK_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              case (rk)
                RK_ADDR: begin
                  if (sh[7:1] == SLAVE_ADDR) begin
                    sda_oe  <= 1'b1;
                    st      <= ST_RX_ACK;
                    rd_mode <= sh[0];
                    if (sh[0]) begin
                      ptr      <= byte_mode ? {1'b0, offs} : 8'd0;
                      send_cnt <= ~byte_mode;
                    end
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                RK_CMD: begin
                  sda_oe    <= 1'b1;
                  st        <= ST_RX_ACK;
                  byte_mode <= sh[7];
                  offs      <= sh[6:0];
                  ptr       <= '0;
                  cnt_seen  <= 1'b0;
                  one_done  <= 1'b0;
                end
                default: begin
                  if (byte_mode) begin
                    if (!one_done) begin
                      sda_oe    <= 1'b1;
                      st        <= ST_RX_ACK;
                      bus_we    <= 1'b1;
                      bus_idx   <= {1'b0, offs};
                      bus_wdata <= sh;
                      one_done  <= 1'b1;
                    end else begin
                      st <= ST_WAIT;
                    end
                  end else if (!cnt_seen) begin
                    sda_oe   <= 1'b1;
                    st       <= ST_RX_ACK;
                    cnt_seen <= 1'b1;
                  end else if (ptr_in_rng) begin
                    sda_oe    <= 1'b1;
                    st        <= ST_RX_ACK;
                    bus_we    <= 1'b1;
                    bus_idx   <= ptr;
                    bus_wdata <= sh;
                    ptr       <= ptr + 8'd1;
                  end else begin
                    st <= ST_WAIT;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bcnt   <= '0;
              sda_oe <= 1'b0;
              if (rd_mode) begin
                sh     <= tx_byte;
                sda_oe <= ~tx_byte[7];
                st     <= ST_TX;
                if (send_cnt) send_cnt <= 1'b0;
                else          ptr      <= ptr + 8'd1;
              end else begin
                st <= ST_RX;
                rk <= (rk == RK_ADDR) ? RK_CMD : RK_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise && sda_s) begin
              st <= ST_WAIT;
            end else if (scl_fall) begin
              bcnt   <= '0;
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[7];
              st     <= ST_TX;
              if (send_cnt) send_cnt <= 1'b0;
              else          ptr      <= ptr + 8'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_idx_regfile.sv
module smb_idx_regfile
  import smb_idx_pkg::*;
#(
  parameter int                      NUM_REGS = 8,
  parameter logic [NUM_REGS*8-1:0]   WR_MASK  = '1,
  parameter logic [NUM_REGS*8-1:0]   W1C_MASK = '0,
  parameter logic [NUM_REGS*8-1:0]   RST_VAL  = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_we,
  input  logic [7:0]              bus_idx,
  input  logic [7:0]              bus_wdata,
  input  logic                    hw_we,
  input  logic [7:0]              hw_idx,
  input  logic [7:0]              hw_wdata,
  input  logic [7:0]              rd_idx,
  output logic [7:0]              rd_data,
  output logic [NUM_REGS*8-1:0]   cfg_q
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= RST_VAL[g*8 +: 8];
      end else if (hw_we && hw_idx == 8'(g)) begin
        q <= hw_wdata;
      end else if (bus_we && bus_idx == 8'(g)) begin
        q <= merge_wr(q, bus_wdata, WR_MASK[g*8 +: 8], W1C_MASK[g*8 +: 8]);
      end
    end
    assign cfg_q[g*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == 8'(i)) rd_data = cfg_q[i*8 +: 8];
    end
  end

endmodule

// File: rtl/smb_idx_regs.sv
module smb_idx_regs #(
  parameter int                    NUM_REGS    = 8,
  parameter logic [6:0]            SLAVE_ADDR  = 7'h69,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] WR_MASK     = 64'hFFFF_F000_F07F_FFFF,
  parameter logic [NUM_REGS*8-1:0] W1C_MASK    = 64'h0000_0F00_0000_0000,
  parameter logic [NUM_REGS*8-1:0] RST_VAL     = 64'hA500_0048_007F_FF00
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  hw_we,
  input  logic [7:0]            hw_idx,
  input  logic [7:0]            hw_wdata,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_idx, rd_data;
  logic       bus_we;
  logic [7:0] bus_idx, bus_wdata;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_idx_fsm #(.NUM_REGS(NUM_REGS), .SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .bus_we    (bus_we),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .sda_oe    (sda_oe)
  );

  smb_idx_regfile #(
    .NUM_REGS (NUM_REGS),
    .WR_MASK  (WR_MASK),
    .W1C_MASK (W1C_MASK),
    .RST_VAL  (RST_VAL)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .hw_we     (hw_we),
    .hw_idx    (hw_idx),
    .hw_wdata  (hw_wdata),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .cfg_q     (cfg_q)
  );

endmodule

// File: rtl/smb_idx_regs_chk.sv
module smb_idx_regs_chk #(
  parameter int                    NUM_REGS = 8,
  parameter logic [NUM_REGS*8-1:0] WR_MASK  = '1,
  parameter logic [NUM_REGS*8-1:0] W1C_MASK = '0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic                  hw_we,
  input logic                  bus_we,
  input logic [NUM_REGS*8-1:0] cfg_q
);

  localparam logic [NUM_REGS*8-1:0] RO_MASK = ~(WR_MASK | W1C_MASK);

  assert_release_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !sda_oe);

  assert_drive_starts_scl_low_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  assert_ro_bits_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(hw_we) |-> ((cfg_q & RO_MASK) == ($past(cfg_q) & RO_MASK)));

  assert_w1c_never_sets_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(hw_we) |-> ((cfg_q & ~$past(cfg_q) & W1C_MASK) == '0));

  assert_change_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(hw_we) && !$past(bus_we)) |-> $stable(cfg_q));

endmodule

bind smb_idx_regs smb_idx_regs_chk #(
  .NUM_REGS (NUM_REGS),
  .WR_MASK  (WR_MASK),
  .W1C_MASK (W1C_MASK)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .scl_i  (scl_i),
  .sda_oe (sda_oe),
  .hw_we  (hw_we),
  .bus_we (bus_we),
  .cfg_q  (cfg_q)
);

// File: tb/smb_idx_regs_bench.sv
module smb_idx_regs_bench;

  localparam int          NR   = 8;
  localparam int          Q    = 5;
  localparam logic [6:0]  ADDR = 7'h69;
  localparam logic [63:0] B_WR  = 64'hFFFF_F000_F07F_FFFF;
  localparam logic [63:0] B_W1C = 64'h0000_0F00_0000_0000;
  localparam logic [63:0] B_RST = 64'hA500_0048_007F_FF00;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         m_scl = 1'b1;
  logic         m_sda_low = 1'b0;
  logic         hw_we = 1'b0;
  logic [7:0]   hw_idx = '0;
  logic [7:0]   hw_wdata = '0;
  logic         sda_oe;
  logic [NR*8-1:0] cfg_q;
  wire          sda_line = ~(m_sda_low | sda_oe);

  always #10 clk = ~clk;

  smb_idx_regs #(
    .NUM_REGS (NR), .SLAVE_ADDR (ADDR),
    .WR_MASK (B_WR), .W1C_MASK (B_W1C), .RST_VAL (B_RST)
  ) u_smb_idx_regs (
    .clk (clk), .rst (rst), .scl_i (m_scl), .sda_i (sda_line), .sda_oe (sda_oe),
    .hw_we (hw_we), .hw_idx (hw_idx), .hw_wdata (hw_wdata), .cfg_q (cfg_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [NR];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic check_cfg(input string tag);
    for (int i = 0; i < NR; i++) check(tag, int'(cfg_q[i*8 +: 8]), int'(exp_r[i]));
  endtask

  function automatic logic [7:0] model_wr(input int i, input logic [7:0] d);
    logic [7:0] r;
    r = exp_r[i];
    for (int b = 0; b < 8; b++) begin
      if (B_W1C[i*8+b]) begin
        if (d[b]) r[b] = 1'b0;
      end else if (B_WR[i*8+b]) begin
        r[b] = d[b];
      end
    end
    return r;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; m_scl = 1'b1; wq();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    m_sda_low = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda_low = 1'b0; wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda_low = ~b; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    m_sda_low = 1'b0; wq();
    m_scl = 1'b1; wq();
    b = sda_line; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~mack);
    m_sda_low = 1'b0;
  endtask

  task automatic byte_wr(input logic [6:0] off, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    put_byte({ADDR, 1'b0}, a0);
    put_byte({1'b1, off}, a1);
    put_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic byte_rd(input logic [6:0] off, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    put_byte({ADDR, 1'b0}, a0);
    put_byte({1'b1, off}, a1);
    bus_rstart();
    put_byte({ADDR, 1'b1}, a2);
    get_byte(d, 1'b0);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic blk_wr(input logic [7:0] cnt, input int nbytes, output int nack_at);
    logic a;
    nack_at = -1;
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h00, a);
    put_byte(cnt, a);
    for (int i = 0; i < nbytes; i++) begin
      put_byte(wbuf[i], a);
      if (!a && nack_at < 0) nack_at = i;
    end
    bus_stop();
  endtask

  task automatic blk_rd(input int nbytes);
    logic a;
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h00, a);
    bus_rstart();
    put_byte({ADDR, 1'b1}, a);
    for (int i = 0; i < nbytes; i++) get_byte(rbuf[i], (i != nbytes - 1));
    bus_stop();
  endtask

  task automatic hw_write(input int idx, input logic [7:0] d);
    @(negedge clk);
    hw_we = 1'b1; hw_idx = 8'(idx); hw_wdata = d;
    @(negedge clk);
    hw_we = 1'b0;
    exp_r[idx] = d;
    @(negedge clk);
  endtask

  initial begin
    logic ok, a;
    logic [7:0] d;
    int na;
    for (int i = 0; i < NR; i++) exp_r[i] = B_RST[i*8 +: 8];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 sda released", int'(sda_oe), 0);
    check_cfg("R1 reset value");

    // R6 block read of reset contents
    blk_rd(NR + 1);
    check("R6 block count", int'(rbuf[0]), NR);
    for (int i = 0; i < NR; i++) check("R6 block data", int'(rbuf[i+1]), int'(exp_r[i]));
    check("R12 released after stop", int'(sda_oe), 0);

    // R3/R4 byte write then read
    byte_wr(7'd0, 8'h3C, ok);
    exp_r[0] = model_wr(0, 8'h3C);
    check("R3 byte write acked", int'(ok), 1);
    check_cfg("R3 byte write");
    byte_rd(7'd0, d, ok);
    check("R4 byte read", int'(d), int'(exp_r[0]));

    // R3 second data byte rejected
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h81, a);
    put_byte(8'h11, a);
    check("R3 first data ack", int'(a), 1);
    put_byte(8'h22, a);
    check("R3 second data nack", int'(a), 0);
    bus_stop();
    exp_r[1] = model_wr(1, 8'h11);
    check_cfg("R3 second byte not stored");

    // R2 address mismatch
    bus_start();
    put_byte({7'h6A, 1'b0}, a);
    check("R2 mismatch nack", int'(a), 0);
    put_byte(8'h80, a);
    put_byte(8'h99, a);
    bus_stop();
    bus_start();
    put_byte({7'h68, 1'b0}, a);
    check("R2 mismatch nack low", int'(a), 0);
    put_byte(8'h81, a);
    put_byte(8'h55, a);
    bus_stop();
    check_cfg("R2 mismatch ignored");

    // R7 read-only bits
    for (int r = 2; r <= 4; r++) begin
      byte_wr(7'(r), 8'hFF, ok);
      exp_r[r] = model_wr(r, 8'hFF);
      byte_wr(7'(r), 8'h00, ok);
      exp_r[r] = model_wr(r, 8'h00);
    end
    check_cfg("R7 read-only held");

    // R9 local port
    hw_write(4, 8'h12);
    hw_write(5, 8'hFF);
    check_cfg("R9 local write");
    byte_rd(7'd4, d, ok);
    check("R9 read of local write", int'(d), 8'h12);

    // R8 write-one-to-clear
    byte_wr(7'd5, 8'h35, ok);
    exp_r[5] = model_wr(5, 8'h35);
    check("R8 clear ones", int'(cfg_q[5*8 +: 8]), 8'h3A);
    byte_wr(7'd5, 8'h00, ok);
    exp_r[5] = model_wr(5, 8'h00);
    check("R8 zero keeps", int'(cfg_q[5*8 +: 8]), 8'h0A);
    byte_rd(7'd5, d, ok);
    check("R8 readback", int'(d), int'(exp_r[5]));

    // R5 short block write
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    blk_wr(8'd3, 3, na);
    check("R5 short all acked", na, -1);
    for (int i = 0; i < 3; i++) exp_r[i] = model_wr(i, wbuf[i]);
    check_cfg("R5 short block write");

    // R5 overlong block write
    for (int i = 0; i < NR + 1; i++) wbuf[i] = 8'(8'h11 * (i + 1));
    blk_wr(8'(NR + 1), NR + 1, na);
    check("R5 nack past end", na, NR);
    for (int i = 0; i < NR; i++) exp_r[i] = model_wr(i, wbuf[i]);
    check_cfg("R5 full block write");

    // R10 out-of-range offset
    byte_wr(7'h50, 8'h77, ok);
    check("R10 out of range acked", int'(ok), 1);
    check_cfg("R10 out of range write");
    byte_rd(7'h50, d, ok);
    check("R10 out of range read", int'(d), 0);

    // R11 repeated start aborts a command in flight
    bus_start();
    put_byte({ADDR, 1'b0}, a);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_rstart();
    put_byte({ADDR, 1'b0}, a);
    put_byte(8'h83, a);
    put_byte(8'h44, a);
    bus_stop();
    exp_r[3] = model_wr(3, 8'h44);
    check_cfg("R11 restart");
    check("R12 released after restart", int'(sda_oe), 0);

    // Sweep: every register, three patterns, byte path
    for (int i = 0; i < NR; i++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : 8'(i * 37 + 27);
        byte_wr(7'(i), pat, ok);
        exp_r[i] = model_wr(i, pat);
        byte_rd(7'(i), d, ok);
        check("R4 R7 sweep readback", int'(d), int'(exp_r[i]));
      end
    end
    check_cfg("R7 sweep state");

    blk_rd(NR + 1);
    check("R6 final count", int'(rbuf[0]), NR);
    for (int i = 0; i < NR; i++) check("R6 final data", int'(rbuf[i+1]), int'(exp_r[i]));
    check("R12 final release", int'(sda_oe), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule